// File: doc/BRIEF.md
# Configurable Serial Receive Deserializer

This block takes a serial bit stream for one receive lane whose bits are already recovered and packs it into parallel words. A fast clock drives the block. The static configuration sets whether the bits are inverted, how many bits arrive per fast clock cycle, and whether words are 10 or 8 bits wide. Its outputs are a 10-bit parallel word and a byte clock. The byte clock rises in the same cycle that a new word appears. Its high phase and its low phase each last a fixed number of bit times.

Bits fill the word from bit 0 upward. In 8-bit mode the two spare upper bits of the output carry the two lowest bits of the byte before. The block has no knowledge of word alignment or line coding, so it simply counts bits from the moment it is enabled. A reserved configuration code stops the block and raises an error flag.

Top module: `serdes_rx_deser`

## Requirements
- R1: While `en` is low, `rx_word` reads zero, `byte_clk` and `first_word` read low, and `sd_even`/`sd_odd` are ignored. This state is reached on the first clock edge that samples `en` low.
- R2: When `inv_pol` is 1, each received bit is inverted before it is packed. When `inv_pol` is 0, bits are packed unchanged.
- R3: `rate_sel` 2'b00 (full) takes two bits per fast clock cycle: `sd_even` first, then `sd_odd`. 2'b01 (half) takes `sd_even` once per cycle. 2'b10 (quarter) takes `sd_even` on the first enabled cycle and on every second cycle after it.
- R4: `width_sel` 3'b000 selects 10-bit words on `rx_word[9:0]`. 3'b001 selects 8-bit words, with the data on `rx_word[7:0]`.
- R5: The first bit received for a word lands in bit 0 and later bits fill the higher bits in order. `rx_word` changes in the same cycle that `byte_clk` rises, and that rise comes in the cycle after the clock edge that took the last bit.
- R6: In 10-bit mode `byte_clk` stays high for 4 bit times and then low for 6. It stays low from enable until the first word completes.
- R7: In 8-bit mode `byte_clk` stays high for 4 bit times and then low for 4.
- R8: In 8-bit mode `rx_word[9:8]` holds bits [1:0] of the byte output just before. For the first byte after enable these two bits read zero.
- R9: A reserved `rate_sel` (2'b11) or a reserved `width_sel` (any value other than 3'b000 or 3'b001) drives `cfg_err` high and makes the block act as if `en` were low.
- R10: After reset or on re-enable, the bit count restarts at zero. `first_word` pulses high for exactly one cycle with the first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| inv_pol | input | 1 | Invert every received bit |
| rate_sel | input | 2 | 00 full, 01 half, 10 quarter, 11 reserved |
| width_sel | input | 3 | 000 ten-bit, 001 eight-bit, others reserved |
| sd_even | input | 1 | Serial bit (first bit of the pair at full rate) |
| sd_odd | input | 1 | Second serial bit of the pair at full rate |
| rx_word | output | 10 | Parallel output word |
| byte_clk | output | 1 | Generated word clock |
| first_word | output | 1 | One-cycle pulse marking the first word after enable |
| cfg_err | output | 1 | Reserved configuration selected |

## Verification
A word and the rise of the byte clock are due on the sample taken right after the clock edge that accepts the word's last bit. The bench drives one bit time per task step and checks `rx_word` and `byte_clk` on that step. At quarter rate the first-word pulse can come one cycle before the last step, so the bench counts `first_word` pulses over the whole word and does not look at a single sample. The duty tests check `byte_clk` one cycle after each bit at half rate. The idle and error results are due one edge after `en` falls or a reserved code is applied, and they are checked at that point.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'b00,
    RATE_HALF    = 2'b01,
    RATE_QUARTER = 2'b10,
    RATE_RSVD    = 2'b11
  } rate_e;

  localparam logic [2:0] WSEL_WIDE   = 3'b000;
  localparam logic [2:0] WSEL_NARROW = 3'b001;

  // Legal configuration: any non-reserved rate paired with a defined width.
  function automatic logic cfg_ok(input logic [1:0] rate, input logic [2:0] wsel);
    return (rate != RATE_RSVD) && ((wsel == WSEL_WIDE) || (wsel == WSEL_NARROW));
  endfunction

  // Bits accepted this fast-clock cycle, given rate and decimation phase.
  function automatic logic [1:0] takes_per_cycle(input logic [1:0] rate, input logic phase);
    case (rate)
      RATE_FULL:    return 2'd2;
      RATE_HALF:    return 2'd1;
      RATE_QUARTER: return phase ? 2'd0 : 2'd1;
      default:      return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/rxd_sampler.sv
module rxd_sampler
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       inv,
  input  logic       din_even,
  input  logic       din_odd,
  output logic [1:0] take_n,
  output logic       bit0,
  output logic       bit1
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= 1'b0;
    else if (!run) phase_q <= 1'b0;
    else           phase_q <= ~phase_q;
  end

  assign take_n = run ? takes_per_cycle(rate, phase_q) : 2'd0;
  assign bit0   = din_even ^ inv;
  assign bit1   = din_odd ^ inv;

  // R3
  quarter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rate == RATE_QUARTER && take_n != 2'd0) |=>
      (!run || rate != RATE_QUARTER || take_n == 2'd0));

endmodule

// File: rtl/rxd_assembler.sv
module rxd_assembler #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8,
  parameter int CW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              narrow,
  input  logic [1:0]        take_n,
  input  logic              bit0,
  input  logic              bit1,
  output logic [WORD_W-1:0] word,
  output logic [CW-1:0]     pos,
  output logic              started,
  output logic              first_word
);

  localparam int CARRY_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0]  asm_q, asm_d, word_q;
  logic [CW-1:0]      pos_q;
  logic [CARRY_W-1:0] carry_q;
  logic               started_q, first_q;
  logic [CW:0]        len, sum;
  logic               done;

  always_comb begin
    len   = narrow ? (CW+1)'(NARROW_W) : (CW+1)'(WORD_W);
    sum   = {1'b0, pos_q} + (CW+1)'(take_n);
    done  = run && (sum >= len);
    asm_d = asm_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (take_n != 2'd0 && i == int'(pos_q))     asm_d[i] = bit0;
      if (take_n == 2'd2 && i == int'(pos_q) + 1) asm_d[i] = bit1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0; word_q <= '0; pos_q <= '0; carry_q <= '0;
      started_q <= 1'b0; first_q <= 1'b0;
    end else if (!run) begin
      asm_q <= '0; word_q <= '0; pos_q <= '0; carry_q <= '0;
      started_q <= 1'b0; first_q <= 1'b0;
    end else if (done) begin
      pos_q     <= CW'(sum - len);
      word_q    <= narrow ? {carry_q, asm_d[NARROW_W-1:0]} : asm_d;
      carry_q   <= asm_d[CARRY_W-1:0];
      asm_q     <= '0;
      started_q <= 1'b1;
      first_q   <= !started_q;
    end else begin
      pos_q   <= CW'(sum);
      asm_q   <= asm_d;
      first_q <= 1'b0;
    end
  end

  assign word       = word_q;
  assign pos        = pos_q;
  assign started    = started_q;
  assign first_word = first_q;

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (word_q == '0 && !started_q && !first_q));

  // R10
  first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> !first_q);

  // R8
  first_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && narrow) |-> word_q[WORD_W-1:NARROW_W] == '0);

endmodule

// File: rtl/rxd_byteclk.sv
module rxd_byteclk #(
  parameter int HIGH_T = 4,
  parameter int CW     = 4
) (
  input  logic          started,
  input  logic [CW-1:0] pos,
  output logic          bclk
);

  // High for the first HIGH_T bit positions of each word period.
  assign bclk = started && (pos < CW'(HIGH_T));

endmodule

// File: rtl/serdes_rx_deser.sv
module serdes_rx_deser
  import rxd_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8,
  parameter int HIGH_T   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inv_pol,
  input  logic [1:0]        rate_sel,
  input  logic [2:0]        width_sel,
  input  logic              sd_even,
  input  logic              sd_odd,
  output logic [WORD_W-1:0] rx_word,
  output logic              byte_clk,
  output logic              first_word,
  output logic              cfg_err
);

  localparam int CW = $clog2(WORD_W + 1);

  logic          cfg_good, run, narrow;
  logic [1:0]    take_n;
  logic          bit0, bit1, started;
  logic [CW-1:0] pos;

  assign cfg_good = cfg_ok(rate_sel, width_sel);
  assign run      = en && cfg_good;
  assign narrow   = (width_sel == WSEL_NARROW);
  assign cfg_err  = !cfg_good;

  rxd_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(rate_sel), .inv(inv_pol),
    .din_even(sd_even), .din_odd(sd_odd),
    .take_n(take_n), .bit0(bit0), .bit1(bit1)
  );

  rxd_assembler #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .CW(CW)) u_asm (
    .clk(clk), .rst_n(rst_n), .run(run), .narrow(narrow),
    .take_n(take_n), .bit0(bit0), .bit1(bit1),
    .word(rx_word), .pos(pos), .started(started), .first_word(first_word)
  );

  rxd_byteclk #(.HIGH_T(HIGH_T), .CW(CW)) u_bclk (
    .started(started), .pos(pos), .bclk(byte_clk)
  );

  // Phase-length counters for the duty checks (half rate: one bit per cycle).
  logic [CW:0] hi_cnt, lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; lo_cnt <= '0;
    end else if (byte_clk) begin
      hi_cnt <= (hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  // R6 R7
  bclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(byte_clk) && run && $past(run) && rate_sel == RATE_HALF)
      |-> hi_cnt == (CW+1)'(HIGH_T));

  // R6 R7
  bclk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(byte_clk) && run && $past(run) && rate_sel == RATE_HALF && !first_word)
      |-> lo_cnt == (narrow ? (CW+1)'(NARROW_W - HIGH_T) : (CW+1)'(WORD_W - HIGH_T)));

  // R9
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (rx_word == '0 && !byte_clk));

endmodule

// File: tb/serdes_rx_deser_tb.sv
`timescale 1ns/1ps
module serdes_rx_deser_tb;

  logic       clk = 1'b0;
  logic       rst_n, en, inv_pol, sd_even, sd_odd;
  logic [1:0] rate_sel;
  logic [2:0] width_sel;
  logic [9:0] rx_word;
  logic       byte_clk, first_word, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  int fw_cnt  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serdes_rx_deser u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .inv_pol(inv_pol),
    .rate_sel(rate_sel), .width_sel(width_sel),
    .sd_even(sd_even), .sd_odd(sd_odd),
    .rx_word(rx_word), .byte_clk(byte_clk),
    .first_word(first_word), .cfg_err(cfg_err)
  );

  // rate, width, invert, raw word0, raw word1, expected word0, expected word1
  localparam logic [45:0] VEC [0:4] = '{
    {2'b01, 3'b000, 1'b0, 10'h2A5, 10'h15A, 10'h2A5, 10'h15A},
    {2'b00, 3'b000, 1'b1, 10'h0F3, 10'h3C0, 10'h30C, 10'h03F},
    {2'b10, 3'b001, 1'b0, 10'h0B7, 10'h04C, 10'h0B7, 10'h34C},
    {2'b00, 3'b001, 1'b1, 10'h05E, 10'h0FF, 10'h0A1, 10'h100},
    {2'b01, 3'b001, 1'b0, 10'h002, 10'h081, 10'h002, 10'h281}
  };

  logic [1:0] v_rt;
  logic [2:0] v_ws;
  logic       v_iv;
  logic [9:0] v_w0, v_w1, v_e0, v_e1;
  int         nb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (first_word) fw_cnt++;
  endtask

  task automatic send_word(input logic [9:0] raw, input int nbits, input logic [1:0] rt);
    en = 1'b1;
    if (rt == 2'b00) begin
      for (int j = 0; j < nbits; j += 2) begin
        sd_even = raw[j]; sd_odd = raw[j+1]; tick();
      end
    end else if (rt == 2'b01) begin
      for (int j = 0; j < nbits; j++) begin
        sd_even = raw[j]; tick();
      end
    end else begin
      for (int j = 0; j < nbits; j++) begin
        sd_even = raw[j]; tick(); tick();
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; inv_pol = 1'b0; sd_even = 1'b0; sd_odd = 1'b0;
    rate_sel = 2'b01; width_sel = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset word", rx_word, 0);
    chk("R10 reset byte_clk", byte_clk, 0);
    chk("R10 reset first_word", first_word, 0);
    chk("R9 legal cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    tick();

    // Table: R2 R3 R4 R5 R8 R10 across rates, widths and polarity
    for (int i = 0; i < 5; i++) begin
      {v_rt, v_ws, v_iv, v_w0, v_w1, v_e0, v_e1} = VEC[i];
      en = 1'b0; rate_sel = v_rt; width_sel = v_ws; inv_pol = v_iv;
      tick();
      nb = (v_ws == 3'b001) ? 8 : 10;
      fw_cnt = 0;
      send_word(v_w0, nb, v_rt);
      chk($sformatf("R2 R3 R4 R5 R8 vec%0d word0", i), rx_word, v_e0);
      chk($sformatf("R5 vec%0d byte_clk rise", i), byte_clk, 1);
      chk($sformatf("R10 vec%0d first pulse", i), fw_cnt, 1);
      fw_cnt = 0;
      send_word(v_w1, nb, v_rt);
      chk($sformatf("R2 R3 R4 R8 vec%0d word1", i), rx_word, v_e1);
      chk($sformatf("R10 vec%0d no second pulse", i), fw_cnt, 0);
    end

    // R6: 10-bit duty at half rate
    en = 1'b0; rate_sel = 2'b01; width_sel = 3'b000; inv_pol = 1'b0;
    tick();
    send_word(10'h1C3, 10, 2'b01);
    for (int k = 1; k <= 10; k++) begin
      sd_even = 10'h2E1 >> (k - 1);
      tick();
      chk($sformatf("R6 byte_clk step %0d", k), byte_clk, ((k % 10) < 4) ? 1 : 0);
    end
    chk("R5 word at rise", rx_word, 10'h2E1);

    // R7: 8-bit duty at half rate, plus carry R8
    en = 1'b0; width_sel = 3'b001;
    tick();
    send_word(10'h03A, 8, 2'b01);
    for (int k = 1; k <= 8; k++) begin
      sd_even = 8'hC5 >> (k - 1);
      tick();
      chk($sformatf("R7 byte_clk step %0d", k), byte_clk, ((k % 8) < 4) ? 1 : 0);
    end
    chk("R8 carry word", rx_word, 10'h2C5);

    // R1 / R6 / R10: enable gating and restart
    en = 1'b0; width_sel = 3'b000;
    tick();
    fw_cnt = 0;
    en = 1'b1;
    for (int j = 0; j < 5; j++) begin
      sd_even = 1'b1; tick();
    end
    chk("R6 low before first word", byte_clk, 0);
    chk("R5 no word mid-assembly", rx_word, 0);
    for (int j = 0; j < 5; j++) begin
      sd_even = 1'b1; tick();
    end
    chk("R5 word complete", rx_word, 10'h3FF);
    for (int j = 0; j < 3; j++) begin
      sd_even = 1'b0; tick();
    end
    en = 1'b0;
    tick();
    chk("R1 word cleared", rx_word, 0);
    chk("R1 byte_clk low", byte_clk, 0);
    sd_even = 1'b1;
    for (int j = 0; j < 12; j++) tick();
    chk("R1 bits ignored", rx_word, 0);
    fw_cnt = 0;
    send_word(10'h155, 10, 2'b01);
    chk("R10 restart aligned", rx_word, 10'h155);
    chk("R10 first pulse on re-enable", fw_cnt, 1);

    // R9: reserved rate and width
    en = 1'b0;
    tick();
    rate_sel = 2'b11; width_sel = 3'b000;
    #1;
    chk("R9 reserved rate flag", cfg_err, 1);
    fw_cnt = 0;
    send_word(10'h3FF, 10, 2'b11);
    chk("R9 reserved rate word", rx_word, 0);
    chk("R9 reserved rate byte_clk", byte_clk, 0);
    chk("R9 reserved rate no pulse", fw_cnt, 0);
    rate_sel = 2'b01; width_sel = 3'b110;
    #1;
    chk("R9 reserved width flag", cfg_err, 1);
    send_word(10'h3FF, 10, 2'b01);
    chk("R9 reserved width word", rx_word, 0);
    width_sel = 3'b001;
    #1;
    chk("R9 legal width flag", cfg_err, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule